// File: doc/BRIEF.md
# Masked packed FP32 vector adder

This block adds two vectors of packed IEEE-754 single-precision numbers lane by lane and returns a registered result of up to 512 bits (sixteen 32-bit lanes). A length select chooses 4, 8 or 16 active lanes. A per-lane write mask, with a merge-or-zero choice, decides whether each active lane takes the sum, keeps the previous destination value or is cleared. The second operand can be a single 32-bit scalar sent to every lane. The rounding mode comes from a default mode input, unless a static override is allowed for the operation.

Two operand encodings are supported. The extended encoding honours masking, broadcast and the static rounding override, and it clears every destination bit above the active length. The legacy encoding is a two-operand form. The previous destination value is the first addend, the length is fixed at 128 bits, masking, broadcast and the override are ignored, and destination bits above bit 127 keep their previous contents. Each lane has its own complete FP32 adder. Five exception conditions are collected into sticky flags.

Operands are taken in on a cycle with `in_valid` high. The result, the flags and `out_valid` change on the next rising clock edge. A synchronous active-high reset clears all of these outputs.

Top module: `vfadd_top`

## Requirements
- R1: `vlen_sel` 2'b00 selects 4 active lanes, 2'b01 selects 8, and 2'b10 or 2'b11 selects 16. Lane j uses bits [32j+31:32j]. In the extended encoding every lane above the active count is written with zero.
- R2: An active lane whose mask bit is set, or any active lane when `mask_en` is low, receives the correctly rounded FP32 sum of its two addends.
- R3: With `mask_en` high and `zero_mode` low, an active lane whose mask bit is clear keeps the value on `dst_old` for that lane.
- R4: With `mask_en` high and `zero_mode` high, an active lane whose mask bit is clear is written with 32'h0000_0000.
- R5: When `bcast` is high and `src_b_reg` is low, every lane adds `src_b[31:0]` in place of its own slice. When `src_b_reg` is high, `bcast` does not broadcast.
- R6: Rounding uses `rnd_static` only when the extended encoding, `src_b_reg` high, a 512-bit length and `bcast` high all hold together. In every other case it uses `rnd_default`.
- R7: Rounding-mode codes are 2'b00 nearest-even, 2'b01 toward minus infinity, 2'b10 toward plus infinity and 2'b11 toward zero.
- R8: When `legacy_enc` is high, lanes 0 to 3 compute `dst_old` plus `src_b`. Bits 511:128 keep `dst_old`. `mask_en`, `bcast`, `rnd_static` and `vlen_sel` have no effect.
- R9: Infinity plus infinity of opposite sign gives 32'hFFC0_0000 and raises invalid. A NaN input is returned quieted (bit 22 set), taking the first addend when it is a NaN. Only a signalling NaN raises invalid.
- R10: An exact zero sum from operands of opposite sign is +0, or -0 when rounding toward minus infinity. The sum of two zeros of the same sign keeps that sign.
- R11: A rounded result beyond the largest finite value gives infinity or the largest finite value, as the rounding mode and sign dictate, and raises overflow and inexact.
- R12: `exc_flags` bit order is [0] invalid, [1] denormal operand, [2] overflow, [3] underflow, [4] inexact. Only lanes that receive a sum contribute. Flags stay set until reset.
- R13: `out_valid` is `in_valid` delayed by one clock. `result` holds its value while `in_valid` is low. Reset clears `result`, `exc_flags` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid; capture this cycle |
| vlen_sel | input | 2 | Vector length code |
| legacy_enc | input | 1 | 1 = legacy two-operand encoding |
| src_a | input | 512 | First addend vector (extended encoding) |
| src_b | input | 512 | Second addend vector, or scalar in bits 31:0 |
| dst_old | input | 512 | Previous destination value |
| wmask | input | 16 | Per-lane write mask |
| mask_en | input | 1 | Masking enabled |
| zero_mode | input | 1 | 1 = zero masked lanes, 0 = merge |
| bcast | input | 1 | Broadcast / embedded-control flag |
| src_b_reg | input | 1 | Second operand is a register |
| rnd_static | input | 2 | Static rounding override |
| rnd_default | input | 2 | Default rounding mode |
| out_valid | output | 1 | Result valid |
| result | output | 512 | Destination vector |
| exc_flags | output | 5 | Sticky exception flags |

## Verification
The hardest case to reach is a lane that would raise a flag but must not, because its mask bit is clear or it lies above the active length. A flag from any other lane would hide the error. The stimulus therefore places an infinity-minus-infinity pair only in a masked-off lane and in a lane above the active length, fills every written lane with exact sums, and resets between scenarios so the sticky flags start clear. Rounding-source selection is checked with an exact halfway sum whose result differs between nearest-even and upward rounding. Each of the four qualifying conditions is then removed one at a time.

// File: rtl/vfadd_pkg.sv
package vfadd_pkg;

    localparam int FP_W      = 32;
    localparam int MANT_W    = 24;
    localparam int GRS_W     = 3;
    localparam int EXT_W     = MANT_W + GRS_W;
    localparam int SUM_W     = EXT_W + 1;
    localparam int LEG_LANES = 4;
    localparam logic [FP_W-1:0] QNAN_DFLT = 32'hFFC0_0000;
    localparam logic [FP_W-1:0] QUIET_BIT = 32'h0040_0000;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rnd_mode_e;

    typedef struct packed {
        logic inexact;
        logic underflow;
        logic overflow;
        logic denormal;
        logic invalid;
    } exc_flags_t;

    typedef struct packed {
        logic        sign;
        logic [7:0]  exp;
        logic [22:0] frac;
    } fp32_t;

    function automatic logic is_nan(input fp32_t x);
        return (x.exp == 8'hFF) && (x.frac != '0);
    endfunction

    function automatic logic is_snan(input fp32_t x);
        return is_nan(x) && !x.frac[22];
    endfunction

    function automatic logic is_inf(input fp32_t x);
        return (x.exp == 8'hFF) && (x.frac == '0);
    endfunction

    function automatic logic is_denorm(input fp32_t x);
        return (x.exp == 8'h00) && (x.frac != '0);
    endfunction

    function automatic int lanes_for_len(input logic [1:0] code);
        case (code)
            2'b00:   return 4;
            2'b01:   return 8;
            default: return 16;
        endcase
    endfunction

    function automatic logic [4:0] lead_zeros(input logic [EXT_W-1:0] v);
        logic [4:0] n;
        logic       hit;
        n   = 5'd0;
        hit = 1'b0;
        for (int i = EXT_W - 1; i >= 0; i--) begin
            if (!hit && v[i]) hit = 1'b1;
            else if (!hit)    n = n + 5'd1;
        end
        return n;
    endfunction

endpackage

// File: rtl/vfadd_ctrl.sv
module vfadd_ctrl
    import vfadd_pkg::*;
#(
    parameter int MAX_LANES = 16
) (
    input  logic [1:0]           vlen_sel,
    input  logic                 legacy_enc,
    input  logic [MAX_LANES-1:0] wmask,
    input  logic                 mask_en,
    input  logic                 bcast,
    input  logic                 src_b_reg,
    input  logic [1:0]           rnd_static,
    input  logic [1:0]           rnd_default,
    output logic [MAX_LANES-1:0] lane_active,
    output logic [MAX_LANES-1:0] lane_sum,
    output rnd_mode_e            rm,
    output logic                 bcast_eff
);

    always_comb begin
        int n_act;
        n_act = legacy_enc ? LEG_LANES : lanes_for_len(vlen_sel);
        if (n_act > MAX_LANES) n_act = MAX_LANES;
        for (int j = 0; j < MAX_LANES; j++) begin
            lane_active[j] = (j < n_act);
        end
        lane_sum  = lane_active & ((legacy_enc || !mask_en) ? {MAX_LANES{1'b1}} : wmask);
        bcast_eff = !legacy_enc && bcast && !src_b_reg;
        if (!legacy_enc && src_b_reg && bcast && vlen_sel[1])
            rm = rnd_mode_e'(rnd_static);
        else
            rm = rnd_mode_e'(rnd_default);
    end

endmodule

// File: rtl/vfadd_fp32_add.sv
module vfadd_fp32_add
    import vfadd_pkg::*;
(
    input  logic [FP_W-1:0] op_a,
    input  logic [FP_W-1:0] op_b,
    input  rnd_mode_e       rm,
    output logic [FP_W-1:0] sum,
    output exc_flags_t      flags
);

    fp32_t a, b;
    assign a = op_a;
    assign b = op_b;

    logic [FP_W-1:0] fin_res;
    exc_flags_t      fin_flg;

    // finite-operand datapath: align, add, normalise, round
    always_comb begin
        fp32_t             big, sml;
        logic [7:0]        eb, es, d;
        logic [EXT_W-1:0]  mb_x, ms_x, ms_sh, lost;
        logic [SUM_W-1:0]  s;
        logic [EXT_W-1:0]  nv;
        logic [9:0]        e, e_out, max_sh, sh;
        logic [24:0]       m25;
        logic [22:0]       frac;
        logic              sub, inc, inexact, tiny, rs;

        big = (b[30:0] > a[30:0]) ? b : a;
        sml = (b[30:0] > a[30:0]) ? a : b;
        eb  = (big.exp == 8'd0) ? 8'd1 : big.exp;
        es  = (sml.exp == 8'd0) ? 8'd1 : sml.exp;
        d   = eb - es;
        mb_x = {big.exp != 8'd0, big.frac, 3'b000};
        ms_x = {sml.exp != 8'd0, sml.frac, 3'b000};
        if (d >= 8'(EXT_W)) begin
            ms_sh = {{(EXT_W-1){1'b0}}, |ms_x};
        end else begin
            lost  = (EXT_W'(1) << d[4:0]) - EXT_W'(1);
            ms_sh = ms_x >> d[4:0];
            ms_sh[0] = ms_sh[0] | (|(ms_x & lost));
        end
        sub = big.sign ^ sml.sign;
        s   = sub ? ({1'b0, mb_x} - {1'b0, ms_sh}) : ({1'b0, mb_x} + {1'b0, ms_sh});
        e   = {2'b00, eb};
        rs  = big.sign;

        if (s[SUM_W-1]) begin
            nv = {s[SUM_W-1:2], s[1] | s[0]};
            e  = e + 10'd1;
        end else begin
            max_sh = e - 10'd1;
            sh     = {5'd0, lead_zeros(s[EXT_W-1:0])};
            if (sh > max_sh) sh = max_sh;
            nv = s[EXT_W-1:0] << sh;
            e  = e - sh;
        end

        tiny    = !nv[EXT_W-1];
        inexact = |nv[2:0];
        case (rm)
            RM_NEAR: inc = nv[2] & (nv[1] | nv[0] | nv[3]);
            RM_UP:   inc = inexact & !rs;
            RM_DOWN: inc = inexact & rs;
            default: inc = 1'b0;
        endcase
        m25 = {1'b0, nv[EXT_W-1:3]} + {24'd0, inc};
        if (m25[24]) begin
            e_out = e + 10'd1;
            frac  = m25[23:1];
        end else begin
            e_out = m25[23] ? e : 10'd0;
            frac  = m25[22:0];
        end

        fin_flg          = '0;
        fin_flg.denormal = is_denorm(a) | is_denorm(b);
        if (s == '0) begin
            fin_res = {sub ? (rm == RM_DOWN) : rs, 31'd0};
        end else if (e_out >= 10'd255) begin
            fin_flg.overflow = 1'b1;
            fin_flg.inexact  = 1'b1;
            if ((rm == RM_ZERO) || (rm == RM_UP && rs) || (rm == RM_DOWN && !rs))
                fin_res = {rs, 8'hFE, 23'h7FFFFF};
            else
                fin_res = {rs, 8'hFF, 23'd0};
        end else begin
            fin_res           = {rs, e_out[7:0], frac};
            fin_flg.inexact   = inexact;
            fin_flg.underflow = tiny & inexact;
        end
    end

    // special operand handling takes precedence
    always_comb begin
        flags = '0;
        if (is_nan(a) || is_nan(b)) begin
            flags.invalid = is_snan(a) | is_snan(b);
            sum = is_nan(a) ? (op_a | QUIET_BIT) : (op_b | QUIET_BIT);
        end else if (is_inf(a) && is_inf(b) && (a.sign != b.sign)) begin
            flags.invalid = 1'b1;
            sum = QNAN_DFLT;
        end else if (is_inf(a)) begin
            sum = op_a;
        end else if (is_inf(b)) begin
            sum = op_b;
        end else begin
            sum   = fin_res;
            flags = fin_flg;
        end
    end

endmodule

// File: rtl/vfadd_top.sv
module vfadd_top
    import vfadd_pkg::*;
#(
    parameter int MAX_LANES = 16,
    localparam int VEC_W    = MAX_LANES * FP_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [1:0]           vlen_sel,
    input  logic                 legacy_enc,
    input  logic [VEC_W-1:0]     src_a,
    input  logic [VEC_W-1:0]     src_b,
    input  logic [VEC_W-1:0]     dst_old,
    input  logic [MAX_LANES-1:0] wmask,
    input  logic                 mask_en,
    input  logic                 zero_mode,
    input  logic                 bcast,
    input  logic                 src_b_reg,
    input  logic [1:0]           rnd_static,
    input  logic [1:0]           rnd_default,
    output logic                 out_valid,
    output logic [VEC_W-1:0]     result,
    output logic [4:0]           exc_flags
);

    logic [MAX_LANES-1:0]      lane_active, lane_sum;
    rnd_mode_e                 rm;
    logic                      bcast_eff;
    logic [VEC_W-1:0]          nxt_res;
    logic [MAX_LANES-1:0][4:0] lane_flg;
    exc_flags_t                new_flg;

    vfadd_ctrl #(.MAX_LANES(MAX_LANES)) u_ctrl (
        .vlen_sel    (vlen_sel),
        .legacy_enc  (legacy_enc),
        .wmask       (wmask),
        .mask_en     (mask_en),
        .bcast       (bcast),
        .src_b_reg   (src_b_reg),
        .rnd_static  (rnd_static),
        .rnd_default (rnd_default),
        .lane_active (lane_active),
        .lane_sum    (lane_sum),
        .rm          (rm),
        .bcast_eff   (bcast_eff)
    );

    for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
        logic [FP_W-1:0] add_a, add_b, add_s, old_l;
        exc_flags_t      add_f;

        assign old_l = dst_old[j*FP_W +: FP_W];
        assign add_a = legacy_enc ? old_l : src_a[j*FP_W +: FP_W];
        assign add_b = bcast_eff ? src_b[FP_W-1:0] : src_b[j*FP_W +: FP_W];

        vfadd_fp32_add u_add (
            .op_a  (add_a),
            .op_b  (add_b),
            .rm    (rm),
            .sum   (add_s),
            .flags (add_f)
        );

        assign nxt_res[j*FP_W +: FP_W] =
            lane_sum[j]    ? add_s :
            lane_active[j] ? (zero_mode ? '0 : old_l) :
                             (legacy_enc ? old_l : '0);
        assign lane_flg[j] = lane_sum[j] ? add_f : '0;
    end

    always_comb begin
        new_flg = '0;
        for (int j = 0; j < MAX_LANES; j++) begin
            new_flg = new_flg | exc_flags_t'(lane_flg[j]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            exc_flags <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result    <= nxt_res;
                exc_flags <= exc_flags | new_flg;
            end
        end
    end

endmodule

// File: rtl/vfadd_top_chk.sv
module vfadd_top_chk #(
    parameter int MAX_LANES = 16,
    localparam int VEC_W    = MAX_LANES * 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [1:0]           vlen_sel,
    input logic                 legacy_enc,
    input logic [VEC_W-1:0]     dst_old,
    input logic [MAX_LANES-1:0] wmask,
    input logic                 mask_en,
    input logic                 zero_mode,
    input logic                 out_valid,
    input logic [VEC_W-1:0]     result,
    input logic [4:0]           exc_flags
);

    p_valid_follow_r13: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_drop_r13: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_hold_result_r13: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result));

    p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !legacy_enc && vlen_sel == 2'b00) |=> (result[VEC_W-1:128] == '0));

    p_merge_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !legacy_enc && mask_en && !zero_mode && !wmask[0])
        |=> (result[31:0] == $past(dst_old[31:0])));

    p_zero_lane_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !legacy_enc && mask_en && zero_mode && !wmask[0])
        |=> (result[31:0] == 32'h0));

    p_legacy_upper_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && legacy_enc) |=> (result[VEC_W-1:128] == $past(dst_old[VEC_W-1:128])));

    p_overflow_inexact_r11: assert property (@(posedge clk) disable iff (rst)
        exc_flags[2] |-> exc_flags[4]);

    p_flags_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((exc_flags & $past(exc_flags)) == $past(exc_flags)));

endmodule

bind vfadd_top vfadd_top_chk #(.MAX_LANES(MAX_LANES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .vlen_sel   (vlen_sel),
    .legacy_enc (legacy_enc),
    .dst_old    (dst_old),
    .wmask      (wmask),
    .mask_en    (mask_en),
    .zero_mode  (zero_mode),
    .out_valid  (out_valid),
    .result     (result),
    .exc_flags  (exc_flags)
);

// File: tb/vfadd_top_tb.sv
module vfadd_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NL         = 16;
    localparam int VW         = NL * 32;

    localparam logic [31:0] ONE   = 32'h3F80_0000;
    localparam logic [31:0] TWO   = 32'h4000_0000;
    localparam logic [31:0] THREE = 32'h4040_0000;
    localparam logic [31:0] FOUR  = 32'h4080_0000;
    localparam logic [31:0] FIVE  = 32'h40A0_0000;
    localparam logic [31:0] HALF_ULP = 32'h3380_0000;
    localparam logic [31:0] PINF  = 32'h7F80_0000;
    localparam logic [31:0] NINF  = 32'hFF80_0000;
    localparam logic [31:0] MAXF  = 32'h7F7F_FFFF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [1:0]    vlen_sel = '0;
    logic          legacy_enc = 1'b0;
    logic [VW-1:0] src_a = '0, src_b = '0, dst_old = '0;
    logic [NL-1:0] wmask = '0;
    logic          mask_en = 1'b0, zero_mode = 1'b0, bcast = 1'b0, src_b_reg = 1'b0;
    logic [1:0]    rnd_static = '0, rnd_default = '0;
    logic          out_valid;
    logic [VW-1:0] result;
    logic [4:0]    exc_flags;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vfadd_top u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .vlen_sel(vlen_sel),
        .legacy_enc(legacy_enc), .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
        .wmask(wmask), .mask_en(mask_en), .zero_mode(zero_mode), .bcast(bcast),
        .src_b_reg(src_b_reg), .rnd_static(rnd_static), .rnd_default(rnd_default),
        .out_valid(out_valid), .result(result), .exc_flags(exc_flags)
    );

    function automatic logic [VW-1:0] rep(input logic [31:0] x);
        return {NL{x}};
    endfunction

    task automatic chk(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic defaults();
        vlen_sel = 2'b10; legacy_enc = 1'b0;
        src_a = '0; src_b = '0; dst_old = '0; wmask = '0;
        mask_en = 1'b0; zero_mode = 1'b0; bcast = 1'b0; src_b_reg = 1'b1;
        rnd_static = 2'b00; rnd_default = 2'b00;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic fire();
        @(negedge clk); in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R13 reset out_valid", VW'(out_valid), '0);
        chk("R13 reset result", result, '0);
        chk("R13 reset flags", VW'(exc_flags), '0);
        rst = 1'b0;
    endtask

    task automatic t_length();
        logic [VW-1:0] e;
        defaults(); do_reset();
        src_a = rep(ONE); src_b = rep(TWO); dst_old = rep(32'hDEAD_BEEF);
        fire();
        chk("R2 all 16 lanes sum", result, rep(THREE));
        chk("R2 exact sum no flags", VW'(exc_flags), '0);
        vlen_sel = 2'b00; fire();
        e = '0; e[127:0] = {4{THREE}};
        chk("R1 128-bit upper zero", result, e);
        vlen_sel = 2'b01; fire();
        e = '0; e[255:0] = {8{THREE}};
        chk("R1 256-bit upper zero", result, e);
        vlen_sel = 2'b11; fire();
        chk("R1 code 11 is 512", result, rep(THREE));
    endtask

    task automatic t_merge();
        logic [VW-1:0] e;
        defaults(); do_reset();
        src_a = rep(ONE); src_b = rep(TWO); dst_old = rep(32'hDEAD_BEEF);
        mask_en = 1'b1; zero_mode = 1'b0; wmask = 16'hA5C3;
        fire();
        for (int j = 0; j < NL; j++) e[j*32 +: 32] = wmask[j] ? THREE : 32'hDEAD_BEEF;
        chk("R3 merge keeps old", result, e);
    endtask

    task automatic t_zero();
        logic [VW-1:0] e;
        defaults(); do_reset();
        src_a = rep(ONE); src_b = rep(TWO); dst_old = rep(32'hDEAD_BEEF);
        mask_en = 1'b1; zero_mode = 1'b1; wmask = 16'h3C81;
        fire();
        for (int j = 0; j < NL; j++) e[j*32 +: 32] = wmask[j] ? THREE : 32'h0;
        chk("R4 zero masking", result, e);
        mask_en = 1'b0; fire();
        chk("R2 mask disabled writes all", result, rep(THREE));
    endtask

    task automatic t_bcast();
        logic [VW-1:0] e;
        defaults(); do_reset();
        src_a = rep(ONE); src_b = rep(TWO); src_b[31:0] = FOUR;
        bcast = 1'b1; src_b_reg = 1'b0;
        fire();
        chk("R5 broadcast from memory", result, rep(FIVE));
        src_b_reg = 1'b1; fire();
        e = rep(THREE); e[31:0] = FIVE;
        chk("R5 register source no broadcast", result, e);
    endtask

    task automatic t_round_sel();
        defaults(); do_reset();
        src_a = rep(ONE); src_b = rep(HALF_ULP);
        rnd_default = 2'b00; rnd_static = 2'b10;
        src_b_reg = 1'b1; bcast = 1'b1; vlen_sel = 2'b10;
        fire();
        chk("R6 static override used", result, rep(32'h3F80_0001));
        vlen_sel = 2'b01; fire();
        chk("R6 256-bit uses default", result[255:0], {8{ONE}});
        vlen_sel = 2'b10; bcast = 1'b0; fire();
        chk("R6 no flag uses default", result, rep(ONE));
        bcast = 1'b1; src_b_reg = 1'b0; fire();
        chk("R6 memory source uses default", result, rep(ONE));
        src_b_reg = 1'b1; legacy_enc = 1'b1; dst_old = rep(ONE); fire();
        chk("R6 legacy uses default", result[127:0], {4{ONE}});
    endtask

    task automatic t_round_modes();
        defaults(); do_reset();
        src_b_reg = 1'b1; src_a = rep(ONE); src_b = rep(HALF_ULP);
        rnd_default = 2'b00; fire();
        chk("R7 nearest tie to even down", result, rep(ONE));
        chk("R12 inexact flag bit4", VW'(exc_flags), VW'(5'b10000));
        rnd_default = 2'b10; fire();
        chk("R7 toward plus inf", result, rep(32'h3F80_0001));
        rnd_default = 2'b11; fire();
        chk("R7 toward zero", result, rep(ONE));
        src_a = rep(32'hBF80_0000); src_b = rep(32'hB380_0000);
        rnd_default = 2'b01; fire();
        chk("R7 toward minus inf negative", result, rep(32'hBF80_0001));
        rnd_default = 2'b10; fire();
        chk("R7 toward plus inf negative", result, rep(32'hBF80_0000));
        src_a = rep(ONE); src_b = rep(32'h3440_0000); rnd_default = 2'b00; fire();
        chk("R7 nearest tie to even up", result, rep(32'h3F80_0002));
    endtask

    task automatic t_legacy();
        logic [VW-1:0] e;
        defaults(); do_reset();
        legacy_enc = 1'b1; vlen_sel = 2'b10;
        dst_old = rep(32'h1234_5678); dst_old[127:0] = {4{ONE}};
        src_a = rep(TWO); src_b = rep(TWO); src_b[31:0] = FOUR;
        mask_en = 1'b1; zero_mode = 1'b1; wmask = '0; bcast = 1'b1; src_b_reg = 1'b0;
        fire();
        e = rep(32'h1234_5678); e[127:0] = {THREE, THREE, THREE, FIVE};
        chk("R8 legacy old dest as source upper kept", result, e);
    endtask

    task automatic t_special();
        defaults(); do_reset();
        vlen_sel = 2'b00; src_a = rep(ONE); src_b = rep(TWO);
        src_a[31:0] = PINF; src_b[31:0] = NINF; fire();
        chk("R9 inf minus inf default NaN", VW'(result[31:0]), VW'(32'hFFC0_0000));
        chk("R9 inf minus inf invalid", VW'(exc_flags), VW'(5'b00001));
        do_reset();
        src_a[31:0] = 32'h7F80_0001; src_b[31:0] = ONE; fire();
        chk("R9 signalling NaN quieted", VW'(result[31:0]), VW'(32'h7FC0_0001));
        chk("R9 signalling NaN invalid", VW'(exc_flags), VW'(5'b00001));
        do_reset();
        src_a[31:0] = 32'h7FC0_0000; src_b[31:0] = 32'hFFC0_0005; fire();
        chk("R9 quiet NaN first operand", VW'(result[31:0]), VW'(32'h7FC0_0000));
        chk("R9 quiet NaN no invalid", VW'(exc_flags), '0);
        do_reset();
        src_a[31:0] = 32'h0000_0001; src_b[31:0] = 32'h0000_0001; fire();
        chk("R12 denormal sum", VW'(result[31:0]), VW'(32'h0000_0002));
        chk("R12 denormal flag bit1", VW'(exc_flags), VW'(5'b00010));
    endtask

    task automatic t_signed_zero();
        defaults(); do_reset();
        src_a = rep(32'h0000_0000); src_b = rep(32'h8000_0000);
        rnd_default = 2'b00; fire();
        chk("R10 +0 plus -0 nearest", result, rep(32'h0));
        rnd_default = 2'b01; fire();
        chk("R10 +0 plus -0 toward minus", result, rep(32'h8000_0000));
        src_a = rep(ONE); src_b = rep(32'hBF80_0000); fire();
        chk("R10 cancellation toward minus", result, rep(32'h8000_0000));
        rnd_default = 2'b10; fire();
        chk("R10 cancellation toward plus", result, rep(32'h0));
        src_a = rep(32'h8000_0000); src_b = rep(32'h8000_0000); fire();
        chk("R10 -0 plus -0", result, rep(32'h8000_0000));
    endtask

    task automatic t_overflow();
        defaults(); do_reset();
        src_a = rep(MAXF); src_b = rep(ONE); fire();
        chk("R11 near max no overflow", result, rep(MAXF));
        chk("R11 near max inexact only", VW'(exc_flags), VW'(5'b10000));
        do_reset();
        src_b = rep(MAXF); fire();
        chk("R11 overflow nearest inf", result, rep(PINF));
        chk("R11 overflow flags", VW'(exc_flags), VW'(5'b10100));
        rnd_default = 2'b11; fire();
        chk("R11 overflow toward zero max", result, rep(MAXF));
        src_a = rep(32'hFF7F_FFFF); src_b = rep(32'hFF7F_FFFF);
        rnd_default = 2'b10; fire();
        chk("R11 negative overflow toward plus", result, rep(32'hFF7F_FFFF));
        rnd_default = 2'b01; fire();
        chk("R11 negative overflow toward minus", result, rep(NINF));
    endtask

    task automatic t_flags();
        defaults(); do_reset();
        src_a = rep(ONE); src_b = rep(TWO);
        src_a[31:0] = PINF; src_b[31:0] = NINF;
        mask_en = 1'b1; zero_mode = 1'b0; wmask = 16'hFFFE; fire();
        chk("R12 masked lane raises nothing", VW'(exc_flags), '0);
        mask_en = 1'b0; vlen_sel = 2'b01;
        src_a[31:0] = ONE; src_b[31:0] = TWO;
        src_a[8*32 +: 32] = PINF; src_b[8*32 +: 32] = NINF; fire();
        chk("R12 inactive lane raises nothing", VW'(exc_flags), '0);
        src_a = rep(ONE); src_b = rep(HALF_ULP); vlen_sel = 2'b10; fire();
        src_b = rep(TWO); fire();
        chk("R12 inexact stays set", VW'(exc_flags), VW'(5'b10000));
    endtask

    task automatic t_latency();
        logic [VW-1:0] held;
        defaults(); do_reset();
        src_a = rep(ONE); src_b = rep(TWO);
        @(negedge clk); in_valid = 1'b1;
        chk("R13 valid not yet", VW'(out_valid), '0);
        @(negedge clk); in_valid = 1'b0;
        chk("R13 valid one clock later", VW'(out_valid), VW'(1'b1));
        held = result;
        src_a = rep(FOUR);
        @(negedge clk);
        chk("R13 valid drops", VW'(out_valid), '0);
        chk("R13 result held", result, held);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL R13 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        defaults();
        t_reset();
        t_length();
        t_merge();
        t_zero();
        t_bcast();
        t_round_sel();
        t_round_modes();
        t_legacy();
        t_special();
        t_signed_zero();
        t_overflow();
        t_flags();
        t_latency();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule